// File: doc/BRIEF.md
# Serial Controller Reset Sequencer

This block sequences resets for a two-channel serial controller whose host bus multiplexes address and data. The controller has no dedicated reset pin. A hardware reset is signalled by the bus strobe combination that never occurs in a legal access: the active-low address strobe and the active-low data strobe both low together. Software can also request a reset by writing a two-bit command into a shared master control register. That command resets channel A, channel B, or the whole device.

Every reset is stretched inside the block by a fixed tail of clock cycles. While a reset or its tail is in effect, host writes are discarded. During a reset the block forces the defined reset values onto the affected channel's write registers 0 to 5 and leaves the other bits alone. The strobes are synchronised into the clock domain before they are decoded, so the tail is counted in clock cycles.

Top module: `scc_rst_seq`

## Requirements
- R1: When `addrStrobeN` and `dataStrobeN` are both low on the same rising edge, `chanRstA`, `chanRstB` and `accessBlock` are all high from the third rising edge after it. A single low strobe starts no reset.
- R2: The hardware reset outputs stay high for as long as both strobes stay low.
- R3: Once both strobes go back high, the reset outputs and `accessBlock` stay high through the sixth rising edge. They go low on the seventh rising edge after the first edge that samples the strobes high.
- R4: While `accessBlock` is high, every write presented on `wrEn` is discarded and changes no register.
- R5: A write to index 9 with command field `wrData[7:6]` nonzero starts a software reset. The value 01 resets channel B, 10 resets channel A and 11 resets both (00 means no reset). The selected reset outputs and `accessBlock` are high from the write edge until the fifth rising edge after it.
- R6: `masterCtl[5:0]` takes `wrData[5:0]` on every accepted write to index 9, including one that carries a reset command. `masterCtl[7:6]` always reads 0. Only a strobe hardware reset clears `masterCtl`.
- R7: While a channel is in reset, its registers are forced as follows: register 0 to 00h; register 1 bits 7,6,4,3,1,0 to 0; register 3 bit 0 to 0; register 4 bit 2 to 1; register 5 bits 7,4,3,2,1 to 0. Every other bit is kept, and register 2 is left untouched.
- R8: A channel reset changes no register of the other channel.
- R9: An accepted write to index 0..5 stores `wrData` in that register of channel A when `chanSelA` is 1, or of channel B when it is 0, from the write edge on. Register i sits at bits [8i+7:8i] of `wrRegsA`/`wrRegsB`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| addrStrobeN | input | 1 | Active-low bus address strobe |
| dataStrobeN | input | 1 | Active-low bus data strobe |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register index (0..5 channel, 9 master control) |
| wrData | input | 8 | Write data |
| chanSelA | input | 1 | Channel select for indices 0..5: 1 = A, 0 = B |
| chanRstA | output | 1 | Channel A in reset |
| chanRstB | output | 1 | Channel B in reset |
| accessBlock | output | 1 | Host writes are being discarded |
| masterCtl | output | 8 | Master control register contents |
| wrRegsA | output | 48 | Channel A write registers 0..5 |
| wrRegsB | output | 48 | Channel B write registers 0..5 |

## Verification
A strobe reset reaches the outputs through two synchroniser flops and the counter register, so it is due on the third edge. Its release is due on the seventh edge after the strobes return high. A software reset appears on the write edge itself and clears five edges later, and the forced register values land one edge after the reset output rises. The bench drives and samples on falling edges and counts rising edges from each stimulus. It checks the last cycle in which a signal must still be high and the first cycle in which it must be low, and checks register contents only after the tail has ended.

// File: rtl/scc_rst_pkg.sv
package scc_rst_pkg;

  localparam int REG_W = 8;

  typedef struct packed {
    logic rstA;
    logic rstB;
    logic clrMaster;
    logic wrMaster;
    logic wrA;
    logic wrB;
  } ctlStrobes_t;

  // Bits kept during a channel reset (1 = keep)
  function automatic logic [REG_W-1:0] keepMask(input int idx);
    case (idx)
      0:       keepMask = 8'h00;
      1:       keepMask = 8'h24;
      3:       keepMask = 8'hFE;
      5:       keepMask = 8'h61;
      default: keepMask = 8'hFF;
    endcase
  endfunction

  // Bits forced high during a channel reset
  function automatic logic [REG_W-1:0] setMask(input int idx);
    setMask = (idx == 4) ? 8'h04 : 8'h00;
  endfunction

endpackage

// File: rtl/scc_rst_ctl.sv
module scc_rst_ctl
  import scc_rst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRETCH     = 5,
  parameter int ADDR_W      = 4,
  parameter int NUM_REGS    = 6,
  parameter int MASTER_ADDR = 9
) (
  input  logic              clk,
  input  logic              addrStrobeN,
  input  logic              dataStrobeN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        cmdBits,
  input  logic              chanSelA,
  output ctlStrobes_t       strobes,
  output logic              accessBlock
);

  localparam int CNT_W = $clog2(STRETCH + 1);

  logic [SYNC_STAGES-1:0] asSync;
  logic [SYNC_STAGES-1:0] dsSync;
  logic [CNT_W-1:0]       tailCnt;
  logic                   scopeA;
  logic                   scopeB;
  logic                   hwCond;
  logic                   accessOk;
  logic                   masterHit;
  logic                   swReq;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        asSync <= addrStrobeN;
        dsSync <= dataStrobeN;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        asSync <= {asSync[SYNC_STAGES-2:0], addrStrobeN};
        dsSync <= {dsSync[SYNC_STAGES-2:0], dataStrobeN};
      end
    end
  endgenerate

  assign hwCond      = !asSync[SYNC_STAGES-1] && !dsSync[SYNC_STAGES-1];
  assign accessBlock = hwCond || (tailCnt != '0);
  assign accessOk    = wrEn && !accessBlock;
  assign masterHit   = accessOk && (wrAddr == ADDR_W'(MASTER_ADDR));
  assign swReq       = masterHit && (cmdBits != 2'b00);

  always_ff @(posedge clk) begin
    if (hwCond) begin
      tailCnt <= CNT_W'(STRETCH);
      scopeA  <= 1'b1;
      scopeB  <= 1'b1;
    end else if (swReq) begin
      tailCnt <= CNT_W'(STRETCH);
      scopeA  <= cmdBits[1];
      scopeB  <= cmdBits[0];
    end else if (tailCnt != '0) begin
      tailCnt <= tailCnt - CNT_W'(1);
      if (tailCnt == CNT_W'(1)) begin
        scopeA <= 1'b0;
        scopeB <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.rstA      = scopeA;
    strobes.rstB      = scopeB;
    strobes.clrMaster = hwCond;
    strobes.wrMaster  = masterHit;
    strobes.wrA       = accessOk && (wrAddr < ADDR_W'(NUM_REGS)) && chanSelA;
    strobes.wrB       = accessOk && (wrAddr < ADDR_W'(NUM_REGS)) && !chanSelA;
  end

endmodule

// File: rtl/scc_rst_dp.sv
module scc_rst_dp
  import scc_rst_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 6
) (
  input  logic                      clk,
  input  ctlStrobes_t               strobes,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [REG_W-1:0]          wrData,
  output logic [REG_W-1:0]          masterCtl,
  output logic [NUM_REGS*REG_W-1:0] wrRegsA,
  output logic [NUM_REGS*REG_W-1:0] wrRegsB
);

  localparam int CMD_LSB = REG_W - 2;

  logic [CMD_LSB-1:0] masterBits;
  logic [REG_W-1:0]   regArr [2][NUM_REGS];
  logic [1:0]         chRst;
  logic [1:0]         chWr;

  assign chRst = {strobes.rstB, strobes.rstA};
  assign chWr  = {strobes.wrB, strobes.wrA};

  always_ff @(posedge clk) begin
    if (strobes.clrMaster)
      masterBits <= '0;
    else if (strobes.wrMaster)
      masterBits <= wrData[CMD_LSB-1:0];
  end

  assign masterCtl = {2'b00, masterBits};

  generate
    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
          if (chRst[ch])
            regArr[ch][r] <= (regArr[ch][r] & keepMask(r)) | setMask(r);
          else if (chWr[ch] && (wrAddr == ADDR_W'(r)))
            regArr[ch][r] <= wrData;
        end
        if (ch == 0) begin : g_outA
          assign wrRegsA[r*REG_W +: REG_W] = regArr[ch][r];
        end else begin : g_outB
          assign wrRegsB[r*REG_W +: REG_W] = regArr[ch][r];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/scc_rst_seq.sv
module scc_rst_seq
  import scc_rst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRETCH     = 5,
  parameter int ADDR_W      = 4,
  parameter int NUM_REGS    = 6,
  parameter int MASTER_ADDR = 9,
  localparam int BUS_W      = NUM_REGS * REG_W
) (
  input  logic              clk,
  input  logic              addrStrobeN,
  input  logic              dataStrobeN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              chanSelA,
  output logic              chanRstA,
  output logic              chanRstB,
  output logic              accessBlock,
  output logic [REG_W-1:0]  masterCtl,
  output logic [BUS_W-1:0]  wrRegsA,
  output logic [BUS_W-1:0]  wrRegsB
);

  ctlStrobes_t strobes;

  scc_rst_ctl #(
    .SYNC_STAGES(SYNC_STAGES),
    .STRETCH    (STRETCH),
    .ADDR_W     (ADDR_W),
    .NUM_REGS   (NUM_REGS),
    .MASTER_ADDR(MASTER_ADDR)
  ) ctl_i (
    .clk        (clk),
    .addrStrobeN(addrStrobeN),
    .dataStrobeN(dataStrobeN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .cmdBits    (wrData[REG_W-1:REG_W-2]),
    .chanSelA   (chanSelA),
    .strobes    (strobes),
    .accessBlock(accessBlock)
  );

  scc_rst_dp #(
    .ADDR_W  (ADDR_W),
    .NUM_REGS(NUM_REGS)
  ) dp_i (
    .clk      (clk),
    .strobes  (strobes),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .masterCtl(masterCtl),
    .wrRegsA  (wrRegsA),
    .wrRegsB  (wrRegsB)
  );

  assign chanRstA = strobes.rstA;
  assign chanRstB = strobes.rstB;

endmodule

// File: rtl/scc_rst_seq_chk.sv
module scc_rst_seq_chk #(
  parameter int STRETCH  = 5,
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 6
) (
  input logic                    clk,
  input logic                    addrStrobeN,
  input logic                    dataStrobeN,
  input logic                    wrEn,
  input logic [ADDR_W-1:0]       wrAddr,
  input logic                    chanRstA,
  input logic                    chanRstB,
  input logic                    accessBlock,
  input logic [7:0]              masterCtl,
  input logic [NUM_REGS*8-1:0]   wrRegsA,
  input logic [NUM_REGS*8-1:0]   wrRegsB
);

  logic [3:0] warmCnt = '0;
  logic [7:0] runLen  = '0;
  logic       cold;

  assign cold = (warmCnt < 4'd8);

  always_ff @(posedge clk) begin
    if (cold) warmCnt <= warmCnt + 4'd1;
    if (accessBlock) begin
      if (runLen != 8'hFF) runLen <= runLen + 8'd1;
    end else begin
      runLen <= '0;
    end
  end

  AST_HW_DETECT: assert property (@(posedge clk) disable iff (cold)
    (!$past(addrStrobeN, 3) && !$past(dataStrobeN, 3))
      |-> (chanRstA && chanRstB && accessBlock)); // R1

  AST_TAIL_LENGTH: assert property (@(posedge clk) disable iff (cold)
    $fell(accessBlock) |-> (runLen >= 8'(STRETCH))); // R3

  AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (cold)
    (accessBlock && wrEn && wrAddr == ADDR_W'(2))
      |=> ($stable(wrRegsA[23:16]) && $stable(wrRegsB[23:16]))); // R4

  AST_MASTER_CLEAR: assert property (@(posedge clk) disable iff (cold)
    (!$past(addrStrobeN, 3) && !$past(dataStrobeN, 3))
      |-> (masterCtl == 8'h00)); // R6

  AST_RST_VALUES_A: assert property (@(posedge clk) disable iff (cold)
    chanRstA |=> (wrRegsA[7:0] == 8'h00 && (wrRegsA[15:8] & 8'hDB) == 8'h00
                  && !wrRegsA[24] && wrRegsA[34]
                  && (wrRegsA[47:40] & 8'h9E) == 8'h00)); // R7

  AST_RST_VALUES_B: assert property (@(posedge clk) disable iff (cold)
    chanRstB |=> (wrRegsB[7:0] == 8'h00 && (wrRegsB[15:8] & 8'hDB) == 8'h00
                  && !wrRegsB[24] && wrRegsB[34]
                  && (wrRegsB[47:40] & 8'h9E) == 8'h00)); // R7

  AST_OTHER_CHAN_A: assert property (@(posedge clk) disable iff (cold)
    (accessBlock && !chanRstA) |=> $stable(wrRegsA)); // R8

  AST_OTHER_CHAN_B: assert property (@(posedge clk) disable iff (cold)
    (accessBlock && !chanRstB) |=> $stable(wrRegsB)); // R8

endmodule

bind scc_rst_seq scc_rst_seq_chk #(
  .STRETCH (STRETCH),
  .ADDR_W  (ADDR_W),
  .NUM_REGS(NUM_REGS)
) chk_i (.*);

// File: tb/scc_rst_seq_tb_top.sv
module scc_rst_seq_tb_top;

  logic        clk = 1'b0;
  logic        addrStrobeN = 1'b0;
  logic        dataStrobeN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        chanSelA = 1'b0;
  logic        chanRstA;
  logic        chanRstB;
  logic        accessBlock;
  logic [7:0]  masterCtl;
  logic [47:0] wrRegsA;
  logic [47:0] wrRegsB;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  scc_rst_seq dut_i (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic selA, input logic [3:0] addr, input logic [7:0] data);
    wrEn = 1'b1; chanSelA = selA; wrAddr = addr; wrData = data;
    tick(1);
    wrEn = 1'b0;
  endtask

  task automatic writeAll(input logic selA, input logic [7:0] data);
    for (int i = 0; i < 6; i++) writeReg(selA, 4'(i), data);
  endtask

  // Strobes low from time zero, then released: R1 R2 R3 R6 R7
  task automatic t_powerOn();
    tick(12);
    check("R1 power-on reset outputs", {chanRstA, chanRstB, accessBlock}, 3'b111);
    tick(10);
    check("R2 reset held while strobes low", {chanRstA, chanRstB, accessBlock}, 3'b111);
    addrStrobeN = 1'b1; dataStrobeN = 1'b1;
    tick(6);
    check("R3 tail still active on 6th edge", {chanRstA, chanRstB, accessBlock}, 3'b111);
    tick(1);
    check("R3 tail over on 7th edge", {chanRstA, chanRstB, accessBlock}, 3'b000);
    check("R6 master cleared by hardware reset", masterCtl, 8'h00);
    check("R7 A reset bits", {wrRegsA[47:40] & 8'h9E, wrRegsA[39:32] & 8'h04,
          wrRegsA[31:24] & 8'h01, wrRegsA[15:8] & 8'hDB, wrRegsA[7:0]}, 40'h0004000000);
    check("R7 B reset bits", {wrRegsB[47:40] & 8'h9E, wrRegsB[39:32] & 8'h04,
          wrRegsB[31:24] & 8'h01, wrRegsB[15:8] & 8'hDB, wrRegsB[7:0]}, 40'h0004000000);
  endtask

  // R9 plain writes
  task automatic t_writes();
    writeAll(1'b1, 8'h00);
    writeAll(1'b0, 8'hFF);
    writeReg(1'b0, 4'd9, 8'h3F);
    tick(1);
    check("R9 channel A written", wrRegsA, 48'h0);
    check("R9 channel B written", wrRegsB, 48'hFFFFFFFFFFFF);
    check("R6 master bits written", masterCtl, 8'h3F);
  endtask

  // Single strobe low: R1 negative case
  task automatic t_singleStrobe();
    addrStrobeN = 1'b0;
    tick(6);
    check("R1 address strobe alone", {chanRstA, chanRstB, accessBlock}, 3'b000);
    addrStrobeN = 1'b1; dataStrobeN = 1'b0;
    tick(6);
    check("R1 data strobe alone", {chanRstA, chanRstB, accessBlock}, 3'b000);
    dataStrobeN = 1'b1;
    tick(3);
    check("R9 registers untouched by lone strobe", wrRegsB, 48'hFFFFFFFFFFFF);
  endtask

  // Channel B software reset with a blocked write: R4 R5 R6 R7 R8
  task automatic t_resetB();
    wrEn = 1'b1; chanSelA = 1'b0; wrAddr = 4'd9; wrData = 8'h55;
    tick(1);
    check("R5 channel B reset on write edge", {chanRstA, chanRstB, accessBlock}, 3'b011);
    chanSelA = 1'b1; wrAddr = 4'd2; wrData = 8'h77;
    tick(1);
    wrEn = 1'b0;
    tick(3);
    check("R5 B reset still active on 4th edge", {chanRstB, accessBlock}, 2'b11);
    tick(1);
    check("R5 B reset over on 5th edge", {chanRstA, chanRstB, accessBlock}, 3'b000);
    check("R6 non-command bits kept with command", masterCtl, 8'h15);
    check("R7 channel B reset values", wrRegsB, 48'h61FFFEFF2400);
    check("R8 channel A untouched by B reset", wrRegsA, 48'h0);
    check("R4 blocked write ignored", wrRegsA[23:16], 8'h00);
  endtask

  // Channel A software reset: R5 R7 R8
  task automatic t_resetA();
    writeReg(1'b0, 4'd9, 8'h80);
    check("R5 channel A reset only", {chanRstA, chanRstB, accessBlock}, 3'b101);
    tick(5);
    check("R7 channel A reset values", wrRegsA, 48'h000400000000);
    check("R8 channel B untouched by A reset", wrRegsB, 48'h61FFFEFF2400);
    check("R6 master after command write", masterCtl, 8'h00);
  endtask

  // Full software reset: R5 R6 R7
  task automatic t_resetBoth();
    writeAll(1'b1, 8'hA5);
    writeAll(1'b0, 8'h5A);
    writeReg(1'b1, 4'd9, 8'hEA);
    check("R5 full software reset", {chanRstA, chanRstB, accessBlock}, 3'b111);
    tick(5);
    check("R5 full reset over", {chanRstA, chanRstB, accessBlock}, 3'b000);
    check("R6 master bits kept on full command", masterCtl, 8'h2A);
    check("R7 A after full reset", wrRegsA, 48'h21A5A4A52400);
    check("R7 B after full reset", wrRegsB, 48'h405E5A5A0000);
  endtask

  // Later hardware reset with latency and master clear: R1 R3 R6 R7
  task automatic t_hwLater();
    writeReg(1'b1, 4'd2, 8'h3C);
    writeReg(1'b1, 4'd9, 8'h15);
    addrStrobeN = 1'b0; dataStrobeN = 1'b0;
    tick(2);
    check("R1 no reset output before 3rd edge", {chanRstA, chanRstB}, 2'b00);
    tick(1);
    check("R1 reset outputs on 3rd edge", {chanRstA, chanRstB, accessBlock}, 3'b111);
    tick(3);
    addrStrobeN = 1'b1; dataStrobeN = 1'b1;
    tick(7);
    check("R3 released after tail", accessBlock, 1'b0);
    check("R6 master cleared by strobes", masterCtl, 8'h00);
    check("R7 register 2 kept across hardware reset", wrRegsA, 48'h21A5A43C2400);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    t_powerOn();
    t_writes();
    t_singleStrobe();
    t_resetB();
    t_resetA();
    t_resetBoth();
    t_hwLater();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule